// File: doc/BRIEF.md
# Vector Interrupt Capability Register Block

This block holds the capability structure, in PCI configuration space, for a device that signals interrupts through a table of message vectors. Configuration accesses of one to four bytes arrive as an absolute config byte address, a length and a little-endian data word. The block answers every byte lane that falls inside its twelve-byte window, and lanes outside the window read as zero. Most of the structure is fixed by parameters: the capability identifier, the pointer to the next capability, the vector count, and the BAR index and offsets of the vector table and of the pending-bit array.

Only two bits can be written. They are the global enable and the function mask, both in the upper byte of the control word. They drive the table engine directly. When a write makes pending vectors possibly deliverable, because the enable turned on or the function mask turned off, the block raises a one-cycle rescan request. The table engine uses it to walk its pending bits.

Top module: `intr_cap_regs`

## Requirements
- R1: Capability byte 0 reads the parameter CAP_ID and byte 1 reads NEXT_PTR; writes to either byte never change them.
- R2: The control word at capability bytes 2..3 holds NUM_VEC-1 in bits 10:0 and zero in bits 13:11; these bits ignore writes.
- R3: Control bit 15 is the global enable (output vec_enable) and bit 14 is the function mask (output func_mask); a write that covers byte 3 loads both from that byte's bits 7 and 6, and a write that covers only byte 2 of the control word changes nothing.
- R4: Bytes 4..7 read the little-endian dword BAR_IDX (table at offset 0), and bytes 8..11 read NUM_VEC*16 ORed with BAR_IDX (pending array location).
- R5: An access of length L (1..4) at address A covers bytes A..A+L-1 in ascending order, and lane i uses bits 8i+7:8i of cfg_wdata and cfg_rdata.
- R6: A write to any capability byte other than byte 3, or to any address outside the window, leaves vec_enable and func_mask unchanged.
- R7: rescan_pulse is high for exactly the cycle after a write edge at which vec_enable went 0 to 1 or func_mask went 1 to 0.
- R8: rescan_pulse stays low after writes that turn the enable off, set the mask, or leave both bits as they were.
- R9: While reset is asserted and right after it, vec_enable, func_mask and rescan_pulse are 0.
- R10: Read lanes at or beyond cfg_len, and lanes whose byte address is outside the window, return zero.
- R11: vec_enable and func_mask change only at a clock edge at which cfg_wr is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe, sampled at the clock edge |
| cfg_rd | input | 1 | Read request (read data is combinational) |
| cfg_addr | input | 8 | Absolute config byte address of lane 0 |
| cfg_len | input | 3 | Access length in bytes, 1 to 4 |
| cfg_wdata | input | 32 | Write data, lane i in bits 8i+7:8i |
| cfg_rdata | output | 32 | Read data, unused lanes zero |
| vec_enable | output | 1 | Global vector enable to the table engine |
| func_mask | output | 1 | Function-wide mask to the table engine |
| rescan_pulse | output | 1 | One-cycle request to re-examine pending vectors |

## Verification
The hardest cases to reach are unaligned multi-byte writes where the writable control byte lands in lane 1, 2 or 3. In these the right data byte must be picked, and the nearby read-only bytes must be left alone in the same access. The same goes for writes that flip the enable and the mask together in opposite directions. Directed accesses start at every offset from one byte below the window to past its end. Seeded random accesses then mix lengths, addresses and data bytes, so both control bits go through every before-and-after combination while a reference model tracks the expected enable, mask and rescan request.

// File: rtl/intr_cap_regs.sv
module intr_cap_regs #(
  parameter int          NUM_VEC  = 8,
  parameter int          BAR_IDX  = 2,
  parameter logic [7:0]  BASE_OFF = 8'h40,
  parameter logic [7:0]  CAP_ID   = 8'h11,
  parameter logic [7:0]  NEXT_PTR = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  input  logic [7:0]  cfg_addr,
  input  logic [2:0]  cfg_len,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        vec_enable,
  output logic        func_mask,
  output logic        rescan_pulse
);
  localparam int          CAP_BYTES   = 12;
  localparam int          ENTRY_BYTES = 16;
  localparam int          LANES       = 4;
  localparam logic [10:0] TSIZE       = 11'(NUM_VEC - 1);
  localparam logic [31:0] TBL_LOC     = 32'(BAR_IDX);
  localparam logic [31:0] PBA_LOC     = 32'(NUM_VEC * ENTRY_BYTES) | 32'(BAR_IDX);

  initial assert (BAR_IDX >= 0 && BAR_IDX <= 5 && NUM_VEC >= 1 && NUM_VEC <= 2048)
    else $error("intr_cap_regs: illegal parameters");

  function automatic logic [7:0] cap_byte(input logic [3:0] rel, input logic en, input logic mk);
    case (rel)
      4'd0:    cap_byte = CAP_ID;
      4'd1:    cap_byte = NEXT_PTR;
      4'd2:    cap_byte = TSIZE[7:0];
      4'd3:    cap_byte = {en, mk, 3'b000, TSIZE[10:8]};
      4'd4:    cap_byte = TBL_LOC[7:0];
      4'd5:    cap_byte = TBL_LOC[15:8];
      4'd6:    cap_byte = TBL_LOC[23:16];
      4'd7:    cap_byte = TBL_LOC[31:24];
      4'd8:    cap_byte = PBA_LOC[7:0];
      4'd9:    cap_byte = PBA_LOC[15:8];
      4'd10:   cap_byte = PBA_LOC[23:16];
      4'd11:   cap_byte = PBA_LOC[31:24];
      default: cap_byte = 8'h00;
    endcase
  endfunction

  logic [LANES-1:0] lane_on, lane_in, ctl_hit;
  logic [7:0]       lane_wb [LANES];
  logic [7:0]       new_hi;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [8:0] abs_a;
    logic [8:0] rel_a;
    assign abs_a      = {1'b0, cfg_addr} + 9'(i);
    assign rel_a      = abs_a - {1'b0, BASE_OFF};
    assign lane_on[i] = 3'(i) < cfg_len;
    assign lane_in[i] = (abs_a >= {1'b0, BASE_OFF}) && (rel_a < 9'(CAP_BYTES));
    assign ctl_hit[i] = cfg_wr && lane_on[i] && lane_in[i] && (rel_a == 9'd3);
    assign lane_wb[i] = ctl_hit[i] ? cfg_wdata[8*i +: 8] : 8'h00;
    assign cfg_rdata[8*i +: 8] = (lane_on[i] && lane_in[i])
                                 ? cap_byte(rel_a[3:0], vec_enable, func_mask) : 8'h00;
  end

  assign new_hi = lane_wb[0] | lane_wb[1] | lane_wb[2] | lane_wb[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_enable   <= 1'b0;
      func_mask    <= 1'b0;
      rescan_pulse <= 1'b0;
    end else if (|ctl_hit) begin
      vec_enable   <= new_hi[7];
      func_mask    <= new_hi[6];
      rescan_pulse <= (new_hi[7] & ~vec_enable) | (~new_hi[6] & func_mask);
    end else begin
      rescan_pulse <= 1'b0;
    end
  end

  assert_rescan_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rescan_pulse |-> ($rose(vec_enable) || $fell(func_mask)));
  assert_rescan_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vec_enable) || $fell(func_mask)) |-> rescan_pulse);
  assert_ctl_only_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable({vec_enable, func_mask}));
  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> (!vec_enable && !func_mask && !rescan_pulse));

  always_comb begin
    if (rst_n && cfg_rd && cfg_addr == BASE_OFF)
      assert_id_read_R1: assert (cfg_rdata[7:0] == CAP_ID);
    if (rst_n && cfg_rd && cfg_len == 3'd1)
      assert_zero_fill_R10: assert (cfg_rdata[31:8] == 24'h0);
  end
endmodule

// File: tb/sim_intr_cap_regs.sv
`timescale 1ns/1ps
module sim_intr_cap_regs;
  localparam int         N    = 8;
  localparam int         BAR  = 2;
  localparam logic [7:0] BASE = 8'h40;
  localparam logic [7:0] ID   = 8'h11;
  localparam logic [7:0] NXT  = 8'h00;

  logic clk = 0, rst_n = 0, cfg_wr = 0, cfg_rd = 0;
  logic [7:0] cfg_addr = 0;
  logic [2:0] cfg_len = 1;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic vec_enable, func_mask, rescan_pulse;
  int checks = 0, errors = 0;
  bit m_en = 0, m_mk = 0, done = 0;

  always #2.5 clk = ~clk;

  intr_cap_regs #(.NUM_VEC(N), .BAR_IDX(BAR), .BASE_OFF(BASE), .CAP_ID(ID), .NEXT_PTR(NXT)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_len(cfg_len), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .vec_enable(vec_enable), .func_mask(func_mask), .rescan_pulse(rescan_pulse));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int a, input bit en, input bit mk);
    int r = a - int'(BASE);
    logic [31:0] pba = 32'(N * 16) | 32'(BAR);
    case (r)
      0: return ID;
      1: return NXT;
      2: return 8'(N - 1);
      3: return {en, mk, 6'b0};
      4: return 8'(BAR);
      8, 9, 10, 11: return pba[8*(r-8) +: 8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input int a, input int len, input bit en, input bit mk);
    logic [31:0] v = 0;
    for (int l = 0; l < len; l++) v[8*l +: 8] = exp_byte(a + l, en, mk);
    return v;
  endfunction

  task automatic op(input bit wr, input int a, input int len, input logic [31:0] d);
    bit hit = 0, ne, nm, exp_rs;
    logic [7:0] hb = 0;
    @(negedge clk);
    cfg_wr = wr; cfg_rd = !wr; cfg_addr = 8'(a); cfg_len = 3'(len); cfg_wdata = d;
    #1;
    if (!wr) chk(cfg_rdata === exp_read(a, len, m_en, m_mk), "R10/R4/R5 read", cfg_rdata, exp_read(a, len, m_en, m_mk));
    for (int l = 0; l < len; l++)
      if (wr && a + l == int'(BASE) + 3) begin hit = 1; hb = d[8*l +: 8]; end
    ne = hit ? hb[7] : m_en;
    nm = hit ? hb[6] : m_mk;
    exp_rs = (ne && !m_en) || (!nm && m_mk);
    m_en = ne; m_mk = nm;
    @(posedge clk); #1;
    chk({vec_enable, func_mask} === {m_en, m_mk}, "R3/R6 ctl bits", {30'b0, vec_enable, func_mask}, {30'b0, m_en, m_mk});
    chk(rescan_pulse === exp_rs, "R7/R8 rescan", {31'b0, rescan_pulse}, {31'b0, exp_rs});
    cfg_wr = 0; cfg_rd = 0;
    @(posedge clk); #1;
    chk(rescan_pulse === 1'b0, "R7 single cycle", {31'b0, rescan_pulse}, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(42));
    repeat (3) @(posedge clk);
    #1;
    chk({vec_enable, func_mask, rescan_pulse} === 3'b000, "R9 in reset", {29'b0, vec_enable, func_mask, rescan_pulse}, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk({vec_enable, func_mask, rescan_pulse} === 3'b000, "R9 after reset", {29'b0, vec_enable, func_mask, rescan_pulse}, 0);
    op(0, BASE, 4, 0);                        // R1 R2 id, next, size
    op(0, BASE + 4, 4, 0);                    // R4 table location
    op(0, BASE + 8, 4, 0);                    // R4 pending array location
    op(0, BASE + 2, 1, 0);                    // R10 short read
    op(0, BASE - 2, 4, 0);                    // R10 outside window
    op(0, BASE + 10, 4, 0);                   // R10 past end
    op(1, BASE + 2, 2, 32'h0000_8000);        // R3 R5 lane1 enable, R7 rescan
    op(1, BASE, 4, 32'h4000_0000);            // R5 lane3: mask on, enable off, R8
    op(1, BASE + 2, 1, 32'hFF);               // R3 low control byte ignored
    op(1, BASE, 2, 32'hFFFF);                 // R1 R6 id/next writes ignored
    op(0, BASE, 2, 0);                        // R1 read back
    op(1, BASE + 1, 3, 32'h00C0_0000);        // R5 lane2: enable on, mask stays
    op(1, BASE + 3, 1, 32'h80);               // R7 mask off
    op(1, BASE + 3, 1, 32'h80);               // R8 no change
    op(1, BASE + 4, 4, 32'hFFFF_FFFF);        // R6 R4 location writes ignored
    op(0, BASE + 4, 4, 0);
    op(1, BASE - 1, 4, 32'h4000_0000);        // R6 byte 3 not covered
    op(1, BASE + 3, 1, 32'h00);               // R8 enable off
    op(0, BASE + 2, 2, 0);                    // R2 R3 control word
    for (int k = 0; k < 400; k++) begin
      int a = int'(BASE) - 3 + int'($urandom_range(0, 17));
      int len = int'($urandom_range(1, 4));
      op($urandom_range(0, 1) == 1, a, len, $urandom);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule